// File: doc/BRIEF.md
# Mapped ADC and Digital Output Port Controller

This block sits behind a host I/O window and turns host bus accesses into actions on three kinds of resource: four 8-bit latched digital output ports, a pass-through region for an external real-time clock chip, and an eight-channel analog-to-digital converter interface. Each output port owns a 64-byte region. Every even address in that region selects the same latch, so software may use any mirror. Odd addresses are never decoded.

A host write to the conversion-start register begins a conversion. The converter is modelled as a parallel input bus that the surrounding logic holds steady while a conversion runs. A parameterised cycle counter stands in for the fixed conversion delay, which is 100 µs at the default setting. When the counter expires, all eight channel values are captured. Eight read addresses return the captured results, with the highest channel at the lowest address. A read made during a conversion returns the previous result and raises a stale flag next to the read data.

Top module: `adc_port_ctrl`

## Requirements
- R1: Out of a synchronous active-high reset, all four port latches, all channel results, `bus_rdata`, `rd_stale`, `adc_start` and `adc_busy` are zero.
- R2: A selected write to an even offset in 0x000–0x03E loads port A (`port_out[7:0]`). 0x0C0–0x0FE loads port B (`[15:8]`), 0x100–0x13E loads port C (`[23:16]`) and 0x140–0x17E loads port D (`[31:24]`). Every even address in a region reaches the same latch.
- R3: A selected read of an even port address returns that port's latch value on `bus_rdata` one cycle later. Read data holds when there is no read.
- R4: Odd offsets are not decoded. A read returns 0xFF, and a write changes no latch, starts no conversion and does not assert `rtc_cs`. Accesses with `bus_sel` low have no effect.
- R5: `rtc_cs` is high, in the same cycle, for a selected read or write at an even offset in 0x040–0x07E. A read there returns `rtc_rdata` one cycle later.
- R6: A write to offset 0x090 while idle raises `adc_busy` on the next cycle for exactly CONV_CYCLES cycles. It also pulses `adc_start` high for one cycle.
- R7: On the cycle `adc_busy` falls, all eight channels of `adc_in` are captured (channel n at `adc_in[8n+7:8n]`). The captured values stay unchanged until the next conversion completes.
- R8: Reads at offsets 0x092, 0x094, … 0x0A0 return channels 7, 6, … 0 in descending order.
- R9: A channel read while `adc_busy` is high returns the previous result, with `rd_stale` high alongside the data. `rd_stale` is low for every other read or idle cycle.
- R10: A write to 0x090 while a conversion is busy is ignored: the conversion neither restarts nor extends.
- R11: Reads of offsets 0x080–0x08E, 0x090, 0x0A2–0x0BE and 0x180–0x1FF return 0xFF. Writes there have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Host window selected |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 9 | Byte offset within the window |
| bus_wdata | input | DATA_W | Host write data |
| bus_rdata | output | DATA_W | Registered read data |
| rd_stale | output | 1 | Read returned a result from before the running conversion |
| port_out | output | 4*DATA_W | Four output latches, port A in the low byte |
| rtc_cs | output | 1 | Chip select for the clock chip region |
| rtc_rdata | input | DATA_W | Data returned by the clock chip |
| adc_in | input | 8*DATA_W | Converter values, channel n at byte n |
| adc_start | output | 1 | One-cycle conversion start pulse |
| adc_busy | output | 1 | Conversion in progress |

## Verification
A mis-decoded address shows up one cycle after the access in two ways: the wrong latch changes, or a read returns the wrong byte. An off-by-one conversion counter shows as `adc_busy` falling a cycle early or late, which is visible at once. A result captured at the wrong moment, or a reversed channel map, stays hidden until the channels are read after the conversion. The bench therefore reads every channel after each conversion, reads during busy, and compares all outputs against a behavioural model on every clock.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  localparam int OFS_W  = 9;
  localparam int NPORT  = 4;
  localparam int NCHAN  = 8;
  localparam int PIDX_W = $clog2(NPORT);
  localparam int CIDX_W = $clog2(NCHAN);

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PORT,
    RG_RTC,
    RG_CONV,
    RG_CHAN
  } region_e;

  typedef struct packed {
    region_e             region;
    logic [PIDX_W-1:0]   port;
    logic [CIDX_W-1:0]   chan;
  } decode_t;
endpackage

// File: rtl/adc_port_decode.sv
module adc_port_decode
  import adc_port_pkg::*;
(
  input  logic [OFS_W-1:0] addr,
  output decode_t          dec
);
  localparam logic [5:0] CONV_OFS  = 6'h10;
  localparam logic [5:0] CHAN_FIRST = 6'h12;
  localparam logic [5:0] CHAN_LAST  = 6'h20;

  logic [5:0] rel;
  assign rel = addr[5:0] - CHAN_FIRST;

  always_comb begin
    dec.region = RG_NONE;
    dec.port   = '0;
    dec.chan   = '0;
    if (!addr[0]) begin
      unique case (addr[8:6])
        3'b000: begin dec.region = RG_PORT; dec.port = 2'd0; end
        3'b011: begin dec.region = RG_PORT; dec.port = 2'd1; end
        3'b100: begin dec.region = RG_PORT; dec.port = 2'd2; end
        3'b101: begin dec.region = RG_PORT; dec.port = 2'd3; end
        3'b001: dec.region = RG_RTC;
        3'b010: begin
          if (addr[5:0] == CONV_OFS) begin
            dec.region = RG_CONV;
          end else if (addr[5:0] >= CHAN_FIRST && addr[5:0] <= CHAN_LAST) begin
            dec.region = RG_CHAN;
            dec.chan   = CIDX_W'(NCHAN - 1) - rel[CIDX_W:1];
          end
        end
        default: dec.region = RG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/adc_port_latches.sv
module adc_port_latches
  import adc_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [PIDX_W-1:0]       wr_port,
  input  logic [DATA_W-1:0]       wdata,
  output logic [NPORT*DATA_W-1:0] q
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst)
        q[p*DATA_W +: DATA_W] <= '0;
      else if (wr_en && wr_port == PIDX_W'(p))
        q[p*DATA_W +: DATA_W] <= wdata;
    end

    a_r2_latch_hold: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_port == PIDX_W'(p)) |=> $stable(q[p*DATA_W +: DATA_W]));
  end
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CONV_CYCLES = 20000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_req,
  input  logic [NCHAN*DATA_W-1:0] adc_in,
  input  logic [CIDX_W-1:0]       rd_chan,
  output logic [DATA_W-1:0]       rd_value,
  output logic                    busy,
  output logic                    start_pulse
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0]        cnt;
  logic [NCHAN*DATA_W-1:0] res_q;
  logic                    done;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      cnt         <= '0;
      start_pulse <= 1'b0;
      res_q       <= '0;
    end else begin
      start_pulse <= start_req && !busy;
      if (!busy) begin
        if (start_req) begin
          busy <= 1'b1;
          cnt  <= CNT_LOAD;
        end
      end else if (done) begin
        busy  <= 1'b0;
        res_q <= adc_in;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign rd_value = res_q[rd_chan*DATA_W +: DATA_W];

  // Independent busy-length counter for the checks below
  logic [31:0] chk_len;
  always_ff @(posedge clk) begin
    if (rst)        chk_len <= '0;
    else if (busy)  chk_len <= chk_len + 1;
    else            chk_len <= '0;
  end

  a_r6_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(chk_len) == 32'(CONV_CYCLES - 1));

  a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(res_q));

  a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && start_req && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));

  a_r6_pulse_idle: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> busy && !$past(busy));
endmodule

// File: rtl/adc_port_ctrl.sv
module adc_port_ctrl
  import adc_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CONV_CYCLES = 20000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [OFS_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    rd_stale,
  output logic [NPORT*DATA_W-1:0] port_out,
  output logic                    rtc_cs,
  input  logic [DATA_W-1:0]       rtc_rdata,
  input  logic [NCHAN*DATA_W-1:0] adc_in,
  output logic                    adc_start,
  output logic                    adc_busy
);
  localparam logic [DATA_W-1:0] IDLE_BYTE = '1;

  decode_t          dec;
  logic             wr_go, rd_go;
  logic [DATA_W-1:0] ch_value;

  assign wr_go = bus_sel && bus_wr;
  assign rd_go = bus_sel && bus_rd;

  adc_port_decode u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  adc_port_latches #(.DATA_W(DATA_W)) u_ports (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_go && dec.region == RG_PORT),
    .wr_port (dec.port),
    .wdata   (bus_wdata),
    .q       (port_out)
  );

  adc_conv_ctrl #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk         (clk),
    .rst         (rst),
    .start_req   (wr_go && dec.region == RG_CONV),
    .adc_in      (adc_in),
    .rd_chan     (dec.chan),
    .rd_value    (ch_value),
    .busy        (adc_busy),
    .start_pulse (adc_start)
  );

  assign rtc_cs = (bus_sel && (bus_wr || bus_rd)) && dec.region == RG_RTC;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      rd_stale  <= 1'b0;
    end else begin
      rd_stale <= 1'b0;
      if (rd_go) begin
        unique case (dec.region)
          RG_PORT: bus_rdata <= port_out[dec.port*DATA_W +: DATA_W];
          RG_RTC:  bus_rdata <= rtc_rdata;
          RG_CHAN: begin
            bus_rdata <= ch_value;
            rd_stale  <= adc_busy;
          end
          default: bus_rdata <= IDLE_BYTE;
        endcase
      end
    end
  end

  a_r9_stale_busy: assert property (@(posedge clk) disable iff (rst)
    rd_stale |-> $past(adc_busy) && $past(rd_go));

  a_r5_rtc_even: assert property (@(posedge clk) disable iff (rst)
    rtc_cs |-> !bus_addr[0] && bus_addr[8:6] == 3'b001);

  a_r4_odd_read: assert property (@(posedge clk) disable iff (rst)
    (rd_go && bus_addr[0]) |=> bus_rdata == IDLE_BYTE && !rd_stale);
endmodule

// File: tb/adc_port_ctrl_test.sv
`timescale 1ns/1ps
module adc_port_ctrl_test;
  localparam int DW   = 8;
  localparam int CONV = 40;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_sel, bus_wr, bus_rd;
  logic [8:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_rdata, rtc_rdata;
  logic        rd_stale, rtc_cs, adc_start, adc_busy;
  logic [31:0] port_out;
  logic [63:0] adc_in;

  always #2.5 clk = ~clk;

  adc_port_ctrl #(.DATA_W(DW), .CONV_CYCLES(CONV)) uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rd_stale(rd_stale), .port_out(port_out), .rtc_cs(rtc_cs),
    .rtc_rdata(rtc_rdata), .adc_in(adc_in), .adc_start(adc_start),
    .adc_busy(adc_busy)
  );

  int checks = 0;
  int fails  = 0;
  string phase = "R1 reset";

  // Behavioural reference model
  int m_port[4];
  int m_res[8];
  int m_rdata, m_stale, m_start, m_busy, m_cnt;

  function automatic int port_of(int a);
    if (a < 'h40) return 0;
    if (a >= 'hC0 && a < 'h100) return 1;
    if (a >= 'h100 && a < 'h140) return 2;
    if (a >= 'h140 && a < 'h180) return 3;
    return -1;
  endfunction

  function automatic int chan_of(int a);
    if (a >= 'h92 && a <= 'hA0) return 7 - (a - 'h92) / 2;
    return -1;
  endfunction

  always @(posedge clk) begin
    int a;
    a = int'(bus_addr);
    if (rst) begin
      foreach (m_port[i]) m_port[i] <= 0;
      foreach (m_res[i])  m_res[i]  <= 0;
      m_rdata <= 0; m_stale <= 0; m_start <= 0; m_busy <= 0; m_cnt <= 0;
    end else begin
      m_start <= 0;
      m_stale <= 0;
      if (m_busy) begin
        if (m_cnt == 1) begin
          m_busy <= 0;
          for (int c = 0; c < 8; c++) m_res[c] <= int'(adc_in[c*8 +: 8]);
        end
        m_cnt <= m_cnt - 1;
      end
      if (bus_sel && bus_wr && a % 2 == 0) begin
        if (port_of(a) >= 0) m_port[port_of(a)] <= int'(bus_wdata);
        if (a == 'h90 && !m_busy) begin
          m_busy <= 1; m_cnt <= CONV; m_start <= 1;
        end
      end
      if (bus_sel && bus_rd) begin
        if (a % 2 != 0)              m_rdata <= 'hFF;
        else if (port_of(a) >= 0)    m_rdata <= m_port[port_of(a)];
        else if (a >= 'h40 && a < 'h80) m_rdata <= int'(rtc_rdata);
        else if (chan_of(a) >= 0) begin
          m_rdata <= m_res[chan_of(a)];
          m_stale <= m_busy;
        end else                     m_rdata <= 'hFF;
      end
    end
  end

  task automatic cmp(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", req, phase, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      int a;
      int exp_cs;
      a = int'(bus_addr);
      exp_cs = (bus_sel && (bus_wr || bus_rd) && a % 2 == 0 && a >= 'h40 && a < 'h80) ? 1 : 0;
      for (int p = 0; p < 4; p++) cmp("R2 port latch", int'(port_out[p*8 +: 8]), m_port[p]);
      cmp("R3/R8/R11 read data", int'(bus_rdata), m_rdata);
      cmp("R9 stale flag", int'(rd_stale), m_stale);
      cmp("R6 busy", int'(adc_busy), m_busy);
      cmp("R6 start pulse", int'(adc_start), m_start);
      cmp("R5 rtc select", int'(rtc_cs), exp_cs);
    end
  end

  task automatic access(bit wr, bit rd, int a, int d, bit sel = 1'b1);
    @(posedge clk); #1;
    bus_sel = sel; bus_wr = wr; bus_rd = rd;
    bus_addr = 9'(a); bus_wdata = 8'(d);
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; bus_rd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    checks++; fails++;
    $display("FAIL watchdog [%s] actual=timeout expected=finish", phase);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1; bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    rtc_rdata = 8'h5A;
    for (int c = 0; c < 8; c++) adc_in[c*8 +: 8] = 8'(16 * c + 3);
    idle(4);
    @(negedge clk);
    // R1: explicit reset values
    cmp("R1 ports", int'(port_out), 0);
    cmp("R1 rdata", int'(bus_rdata), 0);
    cmp("R1 busy", int'(adc_busy), 0);
    @(posedge clk); #1 rst = 0;

    phase = "R2 base and mirrors";
    access(1, 0, 'h000, 'h11);
    access(1, 0, 'h03E, 'h22);
    access(1, 0, 'h0C0, 'h33);
    access(1, 0, 'h0FE, 'h34);
    access(1, 0, 'h100, 'h55);
    access(1, 0, 'h17E, 'h66);
    access(1, 0, 'h140, 'h67);
    phase = "R3 readback";
    access(0, 1, 'h012, 0);
    access(0, 1, 'h0D0, 0);
    access(0, 1, 'h120, 0);
    access(0, 1, 'h15C, 0);
    @(negedge clk);
    cmp("R3 port D readback", int'(bus_rdata), 'h67);

    phase = "R4 odd and unselected";
    access(1, 0, 'h001, 'h99);
    access(0, 1, 'h003, 0);
    access(1, 0, 'h091, 0);
    access(1, 0, 'h041, 0);
    access(1, 0, 'h000, 'hAA, 1'b0);
    access(0, 1, 'h000, 0);
    @(negedge clk);
    cmp("R4 port A untouched", int'(port_out[7:0]), 'h22);

    phase = "R5 clock region";
    access(1, 0, 'h040, 'h01);
    access(0, 1, 'h07E, 0);
    @(negedge clk);
    cmp("R5 rtc data", int'(bus_rdata), 'h5A);

    phase = "R11 unused";
    access(0, 1, 'h080, 0);
    access(0, 1, 'h08E, 0);
    access(0, 1, 'h090, 0);
    access(0, 1, 'h0A2, 0);
    access(0, 1, 'h0BE, 0);
    access(0, 1, 'h180, 0);
    access(1, 0, 'h084, 'h12);
    access(1, 0, 'h180, 'h13);
    access(1, 0, 'h092, 'h14);
    @(negedge clk);
    cmp("R11 no conversion", int'(adc_busy), 0);

    phase = "R6 R9 R10 first conversion";
    access(1, 0, 'h090, 0);
    access(0, 1, 'h092, 0);
    @(negedge clk);
    cmp("R9 stale old value", int'(bus_rdata), 0);
    access(1, 0, 'h090, 0);
    idle(CONV);
    phase = "R7 R8 channel order";
    for (int k = 0; k < 8; k++) begin
      access(0, 1, 'h092 + 2 * k, 0);
      @(negedge clk);
      cmp("R8 channel", int'(bus_rdata), 16 * (7 - k) + 3);
    end

    phase = "R7 second conversion";
    for (int c = 0; c < 8; c++) adc_in[c*8 +: 8] = 8'(255 - 7 * c);
    access(1, 0, 'h090, 0);
    access(0, 1, 'h0A0, 0);
    @(negedge clk);
    cmp("R9 stale ch0", int'(bus_rdata), 3);
    idle(CONV);
    access(0, 1, 'h0A0, 0);
    access(0, 1, 'h092, 0);
    @(negedge clk);
    cmp("R7 ch7 captured", int'(bus_rdata), 255 - 49);

    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule